// File: doc/BRIEF.md
# Codec Sample Frame Timing Generator

This block paces a codec's sampling intervals from the internal master clock. A free-running frame counter closes each sampling interval with a one-clock frame strobe that tells the serial side that ADC data is ready. Inside each interval it also raises a one-clock DAC load strobe, placed a set number of master clocks ahead of the frame strobe.

Two register fields control it. A 2-bit rate code picks the interval length by dividing the longest period down by a power of two. A 5-bit advance code moves the DAC load earlier than its default spot, in steps of eight clocks. The advance code is taken in only while the DAC is powered down, so the load point cannot move under a running converter. The serial clock period, in master clocks, sets the default load offset. The block has no data stream. All its pins are plain control and strobe signals, with no valid/ready handshake and no back-pressure.

Top module: `smp_frame_gen`

## Requirements
- R1: While `rst` is high, both `frame_strobe` and `dac_load` are low on the cycle after every reset edge.
- R2: The first `frame_strobe` after reset is seen in the cycle that follows the 2048th rising edge with `rst` low.
- R3: Successive `frame_strobe` pulses are spaced by the period that `rate_sel` selects: 2'b00 gives 2048 clocks, 2'b01 gives 1024, 2'b10 gives 512 and 2'b11 gives 256.
- R4: A change of `rate_sel` acts only at a frame boundary. The interval that is already running finishes with the period it started with.
- R5: `dac_load` is asserted exactly `sclk_cycles + 8*adv` clocks before `frame_strobe`, where `adv` is the latched advance code. With an advance of zero it comes one serial clock period early.
- R6: The load offset is clamped to the current period minus one. For example, a 256-clock period with `sclk_cycles`=256 and an advance of 31 gives an offset of 255.
- R7: `adv_sel` is latched on every clock edge where `dac_on` is low. While `dac_on` is high, the latched advance holds and writes to `adv_sel` have no effect on the load position.
- R8: Each strobe is exactly one clock wide, and each interval holds exactly one `dac_load` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Sampling rate code |
| adv_sel | input | ADV_W (5) | DAC load advance, in 8-clock steps |
| sclk_cycles | input | SCLK_W (9) | Serial clock period in master clocks, a power of two of at least 8 |
| dac_on | input | 1 | DAC powered; high freezes the latched advance |
| frame_strobe | output | 1 | One-clock pulse at the end of each sampling interval |
| dac_load | output | 1 | One-clock DAC load pulse |

## Verification
A wrong frame count or a wrong latched period shows up at the next frame strobe, as a gap that does not match the rate code. That means at most 2048 clocks pass before the error is visible. A wrong offset or a wrong latched advance moves `dac_load` within the same interval. A stale or wrongly accepted advance therefore appears in the first full interval after the write. The bench measures gap and offset on every interval it observes, so each such error is caught within one or two frames.

// File: rtl/smp_frame_pkg.sv
package smp_frame_pkg;
  typedef enum logic [1:0] {
    RATE_SLOW   = 2'b00,
    RATE_HALF   = 2'b01,
    RATE_QUART  = 2'b10,
    RATE_FAST   = 2'b11
  } rate_e;

  localparam int NUM_RATES = 4;
endpackage

// File: rtl/smp_rate_decode.sv
module smp_rate_decode
  import smp_frame_pkg::*;
#(
  parameter int MAX_PERIOD = 2048,
  parameter int PER_W      = 12
) (
  input  rate_e             rate,
  output logic [PER_W-1:0]  period
);
  logic [PER_W-1:0] per_tbl [NUM_RATES];

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_tbl
    assign per_tbl[i] = PER_W'(MAX_PERIOD >> i);
  end

  assign period = per_tbl[rate];
endmodule

// File: rtl/smp_adv_latch.sv
module smp_adv_latch #(
  parameter int ADV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dac_on,
  input  logic [ADV_W-1:0] adv_in,
  output logic [ADV_W-1:0] adv_q
);
  always_ff @(posedge clk) begin
    if (rst)          adv_q <= '0;
    else if (!dac_on) adv_q <= adv_in;
  end
endmodule

// File: rtl/smp_load_offset.sv
module smp_load_offset #(
  parameter int PER_W    = 12,
  parameter int SCLK_W   = 9,
  parameter int ADV_W    = 5,
  parameter int ADV_STEP = 8
) (
  input  logic [SCLK_W-1:0] sclk_cycles,
  input  logic [ADV_W-1:0]  adv,
  input  logic [PER_W-1:0]  period,
  output logic [PER_W-1:0]  offset
);
  localparam int BASE_W = (PER_W > SCLK_W) ? PER_W : SCLK_W;
  localparam int SUM_W  = BASE_W + ADV_W + 4;

  logic [SUM_W-1:0] raw;
  logic [SUM_W-1:0] limit;

  always_comb begin
    raw    = SUM_W'(sclk_cycles) + SUM_W'(adv) * SUM_W'(ADV_STEP);
    limit  = SUM_W'(period) - SUM_W'(1);
    offset = (raw > limit) ? PER_W'(limit) : PER_W'(raw);
  end
endmodule

// File: rtl/smp_frame_counter.sv
module smp_frame_counter #(
  parameter int MAX_PERIOD = 2048,
  parameter int PER_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period_next,
  input  logic [PER_W-1:0] offset,
  output logic [PER_W-1:0] period_cur,
  output logic             frame_strobe,
  output logic             dac_load
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] last_pos;
  logic [PER_W-1:0] load_pos;
  logic             at_last;

  always_comb begin
    last_pos = period_cur - PER_W'(1);
    load_pos = last_pos - offset;
    at_last  = (cnt == last_pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      period_cur   <= PER_W'(MAX_PERIOD);
      frame_strobe <= 1'b0;
      dac_load     <= 1'b0;
    end else begin
      frame_strobe <= at_last;
      dac_load     <= (cnt == load_pos);
      if (at_last) begin
        cnt        <= '0;
        period_cur <= period_next;
      end else begin
        cnt <= cnt + PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/smp_frame_gen.sv
module smp_frame_gen
  import smp_frame_pkg::*;
#(
  parameter int MAX_PERIOD = 2048,
  parameter int ADV_W      = 5,
  parameter int ADV_STEP   = 8,
  parameter int SCLK_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rate_sel,
  input  logic [ADV_W-1:0]  adv_sel,
  input  logic [SCLK_W-1:0] sclk_cycles,
  input  logic              dac_on,
  output logic              frame_strobe,
  output logic              dac_load
);
  localparam int PER_W = $clog2(MAX_PERIOD) + 1;

  logic [PER_W-1:0] period_next;
  logic [PER_W-1:0] period_cur;
  logic [PER_W-1:0] offset;
  logic [ADV_W-1:0] adv_q;

  smp_rate_decode #(.MAX_PERIOD(MAX_PERIOD), .PER_W(PER_W)) u_rate (
    .rate   (rate_e'(rate_sel)),
    .period (period_next)
  );

  smp_adv_latch #(.ADV_W(ADV_W)) u_adv (
    .clk    (clk),
    .rst    (rst),
    .dac_on (dac_on),
    .adv_in (adv_sel),
    .adv_q  (adv_q)
  );

  smp_load_offset #(
    .PER_W(PER_W), .SCLK_W(SCLK_W), .ADV_W(ADV_W), .ADV_STEP(ADV_STEP)
  ) u_off (
    .sclk_cycles (sclk_cycles),
    .adv         (adv_q),
    .period      (period_cur),
    .offset      (offset)
  );

  smp_frame_counter #(.MAX_PERIOD(MAX_PERIOD), .PER_W(PER_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .period_next  (period_next),
    .offset       (offset),
    .period_cur   (period_cur),
    .frame_strobe (frame_strobe),
    .dac_load     (dac_load)
  );
endmodule

// File: rtl/smp_frame_gen_chk.sv
module smp_frame_gen_chk #(
  parameter int MAX_PERIOD = 2048,
  parameter int ADV_W      = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             dac_on,
  input logic             frame_strobe,
  input logic             dac_load,
  input logic [ADV_W-1:0] adv_q
);
  localparam int GAP_W = $clog2(MAX_PERIOD) + 2;

  logic [GAP_W-1:0] gap;
  logic [1:0]       nload;
  logic             seen_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap        <= '0;
      nload      <= '0;
      seen_first <= 1'b0;
    end else begin
      if (frame_strobe)  gap <= GAP_W'(1);
      else if (gap != '1) gap <= gap + GAP_W'(1);
      if (frame_strobe)          nload <= '0;
      else if (dac_load && nload != 2'b11) nload <= nload + 2'b01;
      if (frame_strobe) seen_first <= 1'b1;
    end
  end

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    rst |=> (!frame_strobe && !dac_load)); // R1

  AST_FIRST_FRAME: assert property (@(posedge clk) disable iff (rst)
    (frame_strobe && !seen_first) |-> (gap == GAP_W'(MAX_PERIOD))); // R2

  AST_GAP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |-> ($countones(gap) == 1 && gap >= GAP_W'(MAX_PERIOD >> 3)
                      && gap <= GAP_W'(MAX_PERIOD))); // R3

  AST_NO_COINCIDE: assert property (@(posedge clk) disable iff (rst)
    !(frame_strobe && dac_load)); // R5

  AST_ADV_HELD: assert property (@(posedge clk) disable iff (rst)
    dac_on |=> $stable(adv_q)); // R7

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |=> !frame_strobe); // R8

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dac_load |=> !dac_load); // R8

  AST_ONE_LOAD_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |-> (nload == 2'b01)); // R8
endmodule

bind smp_frame_gen smp_frame_gen_chk #(.MAX_PERIOD(MAX_PERIOD), .ADV_W(ADV_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dac_on       (dac_on),
  .frame_strobe (frame_strobe),
  .dac_load     (dac_load),
  .adv_q        (adv_q)
);

// File: tb/smp_frame_gen_bench.sv
module smp_frame_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rate_sel = 2'b00;
  logic [4:0] adv_sel = 5'd0;
  logic [8:0] sclk_cycles = 9'd8;
  logic       dac_on = 1'b0;
  logic       frame_strobe;
  logic       dac_load;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int last_s = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  smp_frame_gen u_smp_frame_gen (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .adv_sel(adv_sel),
    .sclk_cycles(sclk_cycles), .dac_on(dac_on),
    .frame_strobe(frame_strobe), .dac_load(dac_load)
  );

  function automatic int exp_period(int rate);
    return 2048 >> rate;
  endfunction

  function automatic int exp_off(int rate, int adv, int sclk);
    int raw = sclk + 8 * adv;
    int lim = exp_period(rate) - 1;
    return (raw > lim) ? lim : raw;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic skip_frame();
    do @(negedge clk); while (!frame_strobe);
    last_s = cyc;
  endtask

  task automatic measure(int per, int off, string req);
    int nld = 0;
    int ld = -1;
    do begin
      @(negedge clk);
      if (dac_load) begin nld++; ld = cyc; end
    end while (!frame_strobe);
    check(cyc - last_s == per, {req, " period"}, cyc - last_s, per);
    check(nld == 1, "R8 one load per frame", nld, 1);
    check(cyc - ld == off, {req, " load offset"}, cyc - ld, off);
    last_s = cyc;
  endtask

  task automatic config_and_check(int rate, int adv, int sclk, string req);
    rate_sel = 2'(rate); adv_sel = 5'(adv); sclk_cycles = 9'(sclk);
    skip_frame();
    measure(exp_period(rate), exp_off(rate, adv, sclk), req);
  endtask

  initial begin
    int rel;
    int nld;
    int ld;
    int r;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!frame_strobe && !dac_load, "R1 outputs low in reset",
          int'(frame_strobe) + int'(dac_load), 0);
    rst = 1'b0;
    rel = cyc;
    nld = 0; ld = -1;
    do begin
      @(negedge clk);
      if (dac_load) begin nld++; ld = cyc; end
    end while (!frame_strobe);
    check(cyc - rel == 2048, "R2 first strobe", cyc - rel, 2048);
    check(cyc - ld == 8, "R5 default load offset", cyc - ld, 8);
    check(nld == 1, "R8 first frame load count", nld, 1);
    last_s = cyc;

    // R4 then R3 for each rate code
    r = 0;
    for (int k = 1; k <= 4; k++) begin
      int nr = k % 4;
      rate_sel = 2'(nr);
      measure(exp_period(r), exp_off(r, 0, 8), "R4 old period kept");
      measure(exp_period(nr), exp_off(nr, 0, 8), "R3 new period");
      r = nr;
    end

    // R5 advance sweep at 512-clock period
    config_and_check(2, 0, 8, "R5 adv0");
    config_and_check(2, 1, 8, "R5 adv1");
    config_and_check(2, 2, 8, "R5 adv2");
    config_and_check(2, 30, 8, "R5 adv30");
    config_and_check(2, 31, 8, "R5 adv31");
    config_and_check(0, 31, 256, "R5 adv31 sclk256");

    // R6 clamp
    config_and_check(3, 31, 256, "R6 clamp 255");
    config_and_check(3, 20, 128, "R6 clamp 288");

    // R7 advance ignored while DAC powered
    config_and_check(2, 2, 16, "R7 baseline");
    dac_on = 1'b1;
    adv_sel = 5'd9;
    skip_frame();
    measure(512, 16 + 16, "R7 write ignored");
    dac_on = 1'b0;
    skip_frame();
    measure(512, 16 + 72, "R7 write taken");

    // random mix
    void'($urandom(32'd4242));
    for (int i = 0; i < 10; i++) begin
      int rr = int'($urandom % 4);
      int aa = int'($urandom % 32);
      int ss = 8 << ($urandom % 6);
      config_and_check(rr, aa, ss, "R5 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule